// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block keeps a fixed number of slots, each of which follows one cache line that has missed and is waiting on memory. The cache controller presents a miss with its byte address and a small request tag. The block either opens a new slot for it, folds it into a slot that already follows the same line, or refuses it when every slot is busy. A refusal tells the controller to stall that miss. Lookups that hit in the cache never reach this block, so hits keep flowing while misses are outstanding.

Each open slot moves through three states: free, queued (no memory read sent yet) and in flight (read sent, fill not yet returned). Queued slots send line reads to memory one at a time, oldest first, over a valid/ready handshake. Memory answers with a fill that names the slot. The block then returns the line data together with the line address, the primary request tag and the number of folded secondary misses, and frees the slot.

Top module: `mshr_file`

## Requirements
- R1: After a synchronous active-low reset, every slot is free, `full` is 0, `mem_req_valid` is 0 and `resp_valid` is 0.
- R2: A miss that folds into no slot takes the lowest-numbered free slot. In the same cycle it reports `alloc_accept`=1, `alloc_merged`=0 and that slot number on `alloc_id`. From the next cycle the slot is queued for memory.
- R3: A miss whose line address (byte address without its low log2(LINE_BYTES) bits) equals that of a queued or in-flight slot is accepted with `alloc_merged`=1, and `alloc_id` names that slot. It opens no slot and sends no extra memory read. The slot's fold count goes up by one and saturates at 2^MERGE_W-1.
- R4: `full` is 1 exactly when no slot is free. A miss presented while full that folds into no slot gets `alloc_accept`=0 and changes nothing.
- R5: `mem_req_valid` is 1 while any slot is queued, and `mem_req_id`/`mem_req_addr` show the queued slot that was opened earliest. These values hold until `mem_req_ready` is 1. The accepted slot becomes in flight, so at most one read is issued per cycle.
- R6: A fill with `fill_valid`=1 whose `fill_id` names an in-flight slot leads, one cycle later, to `resp_valid`=1 with that slot number, its line address, its primary tag, its fold count and `fill_data`. The slot is free at that same edge.
- R7: A fill that names a free or queued slot is ignored. No response follows and the slot keeps its state.
- R8: A miss to the line of a slot that is being filled in the same cycle does not fold into it. It is handled as a new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | A cache miss is presented |
| alloc_addr | input | ADDR_W | Byte address of the miss |
| alloc_info | input | INFO_W | Request tag kept for the primary miss |
| alloc_accept | output | 1 | Miss taken (new slot or folded) |
| alloc_merged | output | 1 | Miss folded into an existing slot |
| alloc_id | output | log2(N_ENTRIES) | Slot that took the miss |
| full | output | 1 | No free slot remains |
| mem_req_valid | output | 1 | A line read is offered to memory |
| mem_req_ready | input | 1 | Memory takes the offered read |
| mem_req_id | output | log2(N_ENTRIES) | Slot issuing the read |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address to read |
| fill_valid | input | 1 | Memory returns a line |
| fill_id | input | log2(N_ENTRIES) | Slot the fill belongs to |
| fill_data | input | 8*LINE_BYTES | Returned line |
| resp_valid | output | 1 | A completed line is returned |
| resp_id | output | log2(N_ENTRIES) | Slot that completed |
| resp_addr | output | ADDR_W-log2(LINE_BYTES) | Line address of the completed miss |
| resp_info | output | INFO_W | Primary request tag |
| resp_merges | output | MERGE_W | Count of folded secondary misses |
| resp_data | output | 8*LINE_BYTES | Line data |

## Verification
The bench uses four slots, 16-bit addresses, 16-byte lines and a 2-bit fold count. With four slots, filling the table, refusing a fifth line and folding into a full table all take only a few cycles. The 2-bit count saturates after three folds, so its ceiling is easy to reach. Freeing a middle slot and reusing it lets the read order follow opening age rather than slot number.

// File: rtl/mshr_pkg.sv
// Shared types for the outstanding-miss table.
// Assumes: nothing beyond a 2-bit state encoding.
package mshr_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,   // slot unused
        ST_PEND = 2'd1,   // queued, read not yet sent
        ST_WAIT = 2'd2    // read sent, waiting on fill
    } mshr_st_e;
endpackage

// File: rtl/mshr_low_pick.sv
// Lowest-index picker: grants the lowest set request bit.
// Assumes: W >= 2; idx is meaningful only when any is 1.
module mshr_low_pick #(
    parameter int W   = 4,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  req,
    output logic [W-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                idx = IW'(i);
            end
        end
        any = |req;
    end

    AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0)); // R2
endmodule

// File: rtl/mshr_age_order.sv
// Age matrix: remembers opening order of slots and selects the
// earliest-opened slot among those flagged as queued.
// Assumes: at most one slot opens per cycle (alloc_oh one-hot or 0).
module mshr_age_order #(
    parameter int N   = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  alloc_oh,
    input  logic [N-1:0]  pend,
    output logic [N-1:0]  sel_oh,
    output logic [IW-1:0] sel_idx,
    output logic          any
);
    // older_q[i][j] = 1 means slot i was opened before slot j
    logic [N-1:0] older_q [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        // on opening slot i it becomes younger than every other slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                older_q[i] <= '0;
            end else begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_oh[i])      older_q[i][j] <= 1'b0;
                    else if (alloc_oh[j]) older_q[i][j] <= 1'b1;
                end
            end
        end

        // slot i is chosen when queued and no queued slot is older
        always_comb begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && pend[j] && older_q[j][i]) blocked = 1'b1;
            end
            sel_oh[i] = pend[i] && !blocked;
        end
    end

    // encode the chosen slot
    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_oh[i]) sel_idx = IW'(i);
        end
        any = |pend;
    end

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh) && (any == (sel_oh != '0))); // R5
endmodule

// File: rtl/mshr_entry.sv
// One tracking slot: state, line address, primary tag, fold count.
// Compares its line address against an incoming miss.
// Assumes: the top raises at most one of set_alloc/set_issue/fill_now.
module mshr_entry
    import mshr_pkg::*;
#(
    parameter int LAW     = 12,
    parameter int INFO_W  = 8,
    parameter int MERGE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LAW-1:0]     lk_addr,
    input  logic               fill_now,
    input  logic               set_alloc,
    input  logic               set_merge,
    input  logic               set_issue,
    input  logic [INFO_W-1:0]  new_info,
    output mshr_st_e           st,
    output logic [LAW-1:0]     line,
    output logic [INFO_W-1:0]  info,
    output logic [MERGE_W-1:0] mcnt,
    output logic               match
);
    localparam logic [MERGE_W-1:0] MCNT_MAX = '1;

    // state transitions of the slot
    always_ff @(posedge clk) begin
        if (!rst_n)         st <= ST_FREE;
        else if (fill_now)  st <= ST_FREE;
        else if (set_issue) st <= ST_WAIT;
        else if (set_alloc) st <= ST_PEND;
    end

    // payload capture on opening, fold counting on merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= '0;
            info <= '0;
            mcnt <= '0;
        end else if (set_alloc) begin
            line <= lk_addr;
            info <= new_info;
            mcnt <= '0;
        end else if (set_merge && mcnt != MCNT_MAX) begin
            mcnt <= mcnt + 1'b1;
        end
    end

    // a live slot not retiring this cycle can absorb the miss
    always_comb match = (st != ST_FREE) && !fill_now && (line == lk_addr);

    AST_OPEN_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        set_alloc |-> st == ST_FREE); // R2
    AST_ISSUE_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        set_issue |=> st == ST_WAIT); // R5
    AST_FILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_now |=> st == ST_FREE); // R6
endmodule

// File: rtl/mshr_file.sv
// Outstanding-miss table. Takes cache misses, folds same-line misses,
// sends line reads oldest first and returns filled lines.
// Assumes: fills arrive only for slots whose read was accepted; one
// miss per cycle; N_ENTRIES >= 2 and LINE_BYTES a power of two.
module mshr_file
    import mshr_pkg::*;
#(
    parameter int N_ENTRIES  = 4,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int INFO_W     = 8,
    parameter int MERGE_W    = 2,
    localparam int ID_W      = $clog2(N_ENTRIES),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LAW       = ADDR_W - OFF_W,
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [ADDR_W-1:0]  alloc_addr,
    input  logic [INFO_W-1:0]  alloc_info,
    output logic               alloc_accept,
    output logic               alloc_merged,
    output logic [ID_W-1:0]    alloc_id,
    output logic               full,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ID_W-1:0]    mem_req_id,
    output logic [LAW-1:0]     mem_req_addr,
    input  logic               fill_valid,
    input  logic [ID_W-1:0]    fill_id,
    input  logic [DATA_W-1:0]  fill_data,
    output logic               resp_valid,
    output logic [ID_W-1:0]    resp_id,
    output logic [LAW-1:0]     resp_addr,
    output logic [INFO_W-1:0]  resp_info,
    output logic [MERGE_W-1:0] resp_merges,
    output logic [DATA_W-1:0]  resp_data
);
    mshr_st_e           e_st   [N_ENTRIES];
    logic [LAW-1:0]     e_line [N_ENTRIES];
    logic [INFO_W-1:0]  e_info [N_ENTRIES];
    logic [MERGE_W-1:0] e_mcnt [N_ENTRIES];

    logic [N_ENTRIES-1:0] e_match, e_free, e_pend, e_fill;
    logic [N_ENTRIES-1:0] free_gnt, open_oh, issue_sel;
    logic [ID_W-1:0]      free_idx, hit_idx, issue_idx;
    logic                 any_free, any_pend, hit, fill_fire;
    logic [LAW-1:0]       lk_line;

    assign lk_line = alloc_addr[ADDR_W-1:OFF_W];

    // fill is honoured only for an in-flight slot
    always_comb begin
        fill_fire = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            e_fill[i] = fill_valid && (fill_id == ID_W'(i)) && (e_st[i] == ST_WAIT);
            fill_fire = fill_fire | e_fill[i];
        end
    end

    // per-slot status vectors
    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            e_free[i] = (e_st[i] == ST_FREE);
            e_pend[i] = (e_st[i] == ST_PEND);
        end
    end

    // encode the slot a miss folds into
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (e_match[i]) hit_idx = ID_W'(i);
        end
        hit = |e_match;
    end

    mshr_low_pick #(.W(N_ENTRIES)) u_free_pick (
        .clk(clk), .rst_n(rst_n),
        .req(e_free), .gnt(free_gnt), .idx(free_idx), .any(any_free)
    );

    // accept decision seen by the cache controller
    always_comb begin
        full         = !any_free;
        alloc_merged = alloc_valid && hit;
        alloc_accept = alloc_valid && (hit || any_free);
        alloc_id     = hit ? hit_idx : free_idx;
        open_oh      = (alloc_valid && !hit) ? free_gnt : '0;
    end

    mshr_age_order #(.N(N_ENTRIES)) u_age (
        .clk(clk), .rst_n(rst_n),
        .alloc_oh(open_oh), .pend(e_pend),
        .sel_oh(issue_sel), .sel_idx(issue_idx), .any(any_pend)
    );

    // memory read channel
    always_comb begin
        mem_req_valid = any_pend;
        mem_req_id    = issue_idx;
        mem_req_addr  = e_line[issue_idx];
    end

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        mshr_entry #(.LAW(LAW), .INFO_W(INFO_W), .MERGE_W(MERGE_W)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .lk_addr(lk_line),
            .fill_now(e_fill[i]),
            .set_alloc(open_oh[i]),
            .set_merge(alloc_valid && e_match[i]),
            .set_issue(issue_sel[i] && mem_req_ready),
            .new_info(alloc_info),
            .st(e_st[i]), .line(e_line[i]), .info(e_info[i]),
            .mcnt(e_mcnt[i]), .match(e_match[i])
        );
    end

    // completed-line register, loaded on an honoured fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_id     <= '0;
            resp_addr   <= '0;
            resp_info   <= '0;
            resp_merges <= '0;
            resp_data   <= '0;
        end else begin
            resp_valid <= fill_fire;
            if (fill_fire) begin
                resp_id     <= fill_id;
                resp_addr   <= e_line[fill_id];
                resp_info   <= e_info[fill_id];
                resp_merges <= e_mcnt[fill_id];
                resp_data   <= fill_data;
            end
        end
    end

    AST_REFUSE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && full && !alloc_merged) |-> !alloc_accept); // R4
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(e_match)); // R3
    AST_FILL_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire |=> resp_valid && resp_id == $past(fill_id)); // R6
    AST_IGNORED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_fire) |=> !resp_valid); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_id)); // R5
endmodule

// File: tb/tb_mshr_file.sv
module tb_mshr_file;
    localparam int N = 4, AW = 16, LB = 16, IW = 8, MW = 2;
    localparam int DW = LB * 8, LAW = AW - 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, mem_req_ready = 0, fill_valid = 0;
    logic [AW-1:0] alloc_addr = '0;
    logic [IW-1:0] alloc_info = '0;
    logic [1:0] fill_id = '0;
    logic [DW-1:0] fill_data = '0;
    logic alloc_accept, alloc_merged, full, mem_req_valid, resp_valid;
    logic [1:0] alloc_id, mem_req_id, resp_id;
    logic [LAW-1:0] mem_req_addr, resp_addr;
    logic [IW-1:0] resp_info;
    logic [MW-1:0] resp_merges;
    logic [DW-1:0] resp_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    mshr_file #(.N_ENTRIES(N), .ADDR_W(AW), .LINE_BYTES(LB),
                .INFO_W(IW), .MERGE_W(MW)) dut (.*);

    // {addr[15:0], accept, merged, id[1:0]}
    localparam logic [19:0] VEC [10] = '{
        {16'h0100, 1'b1, 1'b0, 2'd0},
        {16'h0208, 1'b1, 1'b0, 2'd1},
        {16'h010C, 1'b1, 1'b1, 2'd0},
        {16'h0300, 1'b1, 1'b0, 2'd2},
        {16'h0400, 1'b1, 1'b0, 2'd3},
        {16'h0500, 1'b0, 1'b0, 2'd0},
        {16'h0404, 1'b1, 1'b1, 2'd3},
        {16'h0108, 1'b1, 1'b1, 2'd0},
        {16'h0100, 1'b1, 1'b1, 2'd0},
        {16'h0101, 1'b1, 1'b1, 2'd0}
    };

    function automatic logic [DW-1:0] fdat(input logic [1:0] id);
        return {4{30'h3C0D_0000 >> 2, id}};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_alloc(input logic [AW-1:0] a, input logic [IW-1:0] inf,
                            input logic acc, input logic mrg, input logic [1:0] id, input string req);
        @(negedge clk);
        alloc_valid = 1; alloc_addr = a; alloc_info = inf;
        #5;
        chk(req, DW'(alloc_accept), DW'(acc));
        chk(req, DW'(alloc_merged), DW'(mrg));
        if (acc) chk(req, DW'(alloc_id), DW'(id));
        @(posedge clk); #1 alloc_valid = 0;
    endtask

    task automatic do_issue(input logic [1:0] id, input logic [LAW-1:0] la);
        @(negedge clk);
        mem_req_ready = 1;
        #5;
        chk("R5 valid", DW'(mem_req_valid), DW'(1));
        chk("R5 id", DW'(mem_req_id), DW'(id));
        chk("R5 addr", DW'(mem_req_addr), DW'(la));
        @(posedge clk); #1 mem_req_ready = 0;
    endtask

    // drive a fill, then look at the response one cycle later
    task automatic do_fill(input logic [1:0] id, input logic expv, input logic [LAW-1:0] la,
                           input logic [IW-1:0] inf, input logic [MW-1:0] mc, input string req);
        @(negedge clk);
        fill_valid = 1; fill_id = id; fill_data = fdat(id);
        @(posedge clk); #1 fill_valid = 0;
        @(negedge clk); #5;
        chk(req, DW'(resp_valid), DW'(expv));
        if (expv) begin
            chk(req, DW'(resp_id), DW'(id));
            chk(req, DW'(resp_addr), DW'(la));
            chk(req, DW'(resp_info), DW'(inf));
            chk(req, DW'(resp_merges), DW'(mc));
            chk(req, resp_data, fdat(id));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 full", DW'(full), 0);
        chk("R1 req", DW'(mem_req_valid), 0);
        chk("R1 resp", DW'(resp_valid), 0);
        rst_n = 1;

        // R2 R3 R4: fill the table, fold, refuse, saturate
        for (int k = 0; k < 10; k++) begin
            do_alloc(VEC[k][19:4], IW'(8'hA0 + k), VEC[k][3], VEC[k][2], VEC[k][1:0], "R2/R3/R4 table");
        end
        @(negedge clk); #5;
        chk("R4 full", DW'(full), 1);

        // R5: issue in opening order, then channel goes idle
        do_issue(2'd0, 12'h010);
        do_issue(2'd1, 12'h020);
        do_issue(2'd2, 12'h030);
        do_issue(2'd3, 12'h040);
        @(negedge clk); #5;
        chk("R5 idle", DW'(mem_req_valid), 0);

        do_fill(2'd1, 1, 12'h020, 8'hA1, 2'd0, "R6 fill slot1");
        chk("R4 not full", DW'(full), 0);
        do_fill(2'd1, 0, '0, '0, '0, "R7 fill free slot");

        do_alloc(16'h0700, 8'hB0, 1, 0, 2'd1, "R2 reuse lowest");
        do_fill(2'd1, 0, '0, '0, '0, "R7 fill queued slot");
        chk("R7 still queued", DW'(mem_req_id), DW'(1));
        chk("R7 still queued", DW'(mem_req_valid), DW'(1));

        do_fill(2'd0, 1, 12'h010, 8'hA0, 2'd3, "R3 saturated folds");
        do_alloc(16'h0800, 8'hB1, 1, 0, 2'd0, "R2 reuse slot0");
        do_issue(2'd1, 12'h070);   // R5 older slot 1 before slot 0
        do_issue(2'd0, 12'h080);

        do_fill(2'd3, 1, 12'h040, 8'hA4, 2'd1, "R3 one fold");

        // R8: miss to the line being filled this cycle
        @(negedge clk);
        fill_valid = 1; fill_id = 2'd2; fill_data = fdat(2'd2);
        alloc_valid = 1; alloc_addr = 16'h0304; alloc_info = 8'hB2;
        #5;
        chk("R8 accept", DW'(alloc_accept), 1);
        chk("R8 no fold", DW'(alloc_merged), 0);
        chk("R8 new slot", DW'(alloc_id), DW'(3));
        @(posedge clk); #1 fill_valid = 0; alloc_valid = 0;
        @(negedge clk); #5;
        chk("R8 resp", DW'(resp_valid), 1);
        chk("R8 resp id", DW'(resp_id), DW'(2));
        chk("R8 new read", DW'(mem_req_valid), 1);
        chk("R8 new read id", DW'(mem_req_id), DW'(3));
        chk("R8 new read addr", DW'(mem_req_addr), DW'(12'h030));

        // R1: reset again mid-run
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        chk("R1 full", DW'(full), 0);
        chk("R1 req", DW'(mem_req_valid), 0);
        chk("R1 resp", DW'(resp_valid), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule